// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the serial pins of an SPI slave and its command engine. It lets the bus master stop a transaction halfway through and continue it later without sending it again. The block samples SCK, the active-low chip select, the active-low hold input and SI on the system clock. It turns the SCK transitions into one-cycle rising and falling edge enables for the engine. While a pause is in effect it withholds those enables, holds the SI value presented to the engine, and turns the serial output driver off. The engine's shift state is not touched, so after a pause the transfer continues from the same bit.

The start and end of a pause depend on the SCK level at the moment hold changes. A hold assertion seen while SCK is low pauses at once. A hold assertion seen while SCK is high is armed and takes effect at the next SCK falling edge. That falling edge is withheld from the engine. A pause ends only when hold rises while SCK is low. Deselecting the block always clears the pause. Hold transitions while deselected are ignored.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset `paused_o`, `so_oe_o`, `so_o`, `eng_sck_rise_o` and `eng_sck_fall_o` are all 0.
- R2: While `cs_ni` is low and no pause is in effect, each SCK rising and falling transition gives exactly one one-cycle pulse on `eng_sck_rise_o` or `eng_sck_fall_o`. While `cs_ni` is high, no pulses are given.
- R3: When hold falls while SCK is low and the block is selected, `paused_o` goes to 1 two clocks after the input change.
- R4: When hold falls while SCK is high, `paused_o` stays 0 until the next SCK falling transition. The pause then takes effect, and that falling transition gives no `eng_sck_fall_o` pulse.
- R5: If hold returns high before that SCK falling transition, the armed pause is cancelled. The falling transition is then delivered normally and no pause occurs.
- R6: A pause ends two clocks after hold rises while SCK is low. If hold rises while SCK is high, the block stays paused, even after SCK later goes low.
- R7: While paused, no edge pulses are produced, `so_oe_o` is 0 and `eng_si_o` keeps the value it had when the pause began.
- R8: Raising `cs_ni` during a pause clears `paused_o` within two clocks. A later selection starts unpaused.
- R9: When selected and not paused, `so_oe_o` follows `eng_so_oe_i`. `so_o` equals `eng_so_i` while `so_oe_o` is 1 and is 0 otherwise.
- R10: A hold falling transition that occurs while `cs_ni` is high has no effect. A hold level that is already low at selection does not pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock pin level |
| cs_ni | input | 1 | Chip select, active low |
| hold_ni | input | 1 | Pause request, active low |
| si_i | input | 1 | Serial data in |
| eng_so_i | input | 1 | Engine serial data out |
| eng_so_oe_i | input | 1 | Engine wants to drive SO |
| eng_sck_rise_o | output | 1 | One-cycle SCK rising edge enable |
| eng_sck_fall_o | output | 1 | One-cycle SCK falling edge enable |
| eng_si_o | output | 1 | SI value for the engine, held while paused |
| paused_o | output | 1 | Engine freeze indication |
| so_o | output | 1 | Serial output data |
| so_oe_o | output | 1 | Serial output driver enable |

## Verification
With the default single input stage, the edge enables and `eng_si_o` are valid one clock after a pin change. `paused_o` and the SO drive enable settle two clocks after the pin change, and deselection turns SO off one clock after `cs_ni` rises. The directed tasks change pins just after a clock edge and sample just after the edge where each result is due. They count edge pulses on the opposite clock phase, so that each pulse is counted exactly once. For the deferred-entry case, the bench checks at the clock that delivers the withheld SCK fall that no fall pulse appeared and that the pause is not yet visible. One clock later it checks that the pause is in effect.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    HS_RUN    = 2'd0,
    HS_ARMED  = 2'd1,
    HS_PAUSED = 2'd2
  } hold_state_e;

  localparam int unsigned PIN_SCK  = 0;
  localparam int unsigned PIN_CS   = 1;
  localparam int unsigned PIN_HOLD = 2;
  localparam int unsigned PIN_SI   = 3;
  localparam int unsigned PIN_W    = 4;
  // deselected, hold released
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0110;
endpackage

// File: rtl/spi_pin_stage.sv
module spi_pin_stage #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);
  localparam int unsigned LAST = (STAGES > 0) ? STAGES - 1 : 0;

  logic [LAST:0][WIDTH-1:0] sr_q;
  logic [WIDTH-1:0]         prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= {(LAST+1){RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i <= LAST; i++) sr_q[i] <= sr_q[i-1];
      prev_q <= sr_q[LAST];
    end
  end

  assign cur_o  = sr_q[LAST];
  assign prev_o = prev_q;
endmodule

// File: rtl/hold_pause_fsm.sv
module hold_pause_fsm
  import spi_hold_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        sck_prev_i,
  input  logic        hold_ni,
  input  logic        hold_prev_ni,
  input  logic        cs_ni,
  output hold_state_e state_o,
  output logic        block_o,
  output logic        drive_o
);
  hold_state_e st_q, st_d;
  logic        drive_q;
  logic        sel, h_fall, h_rise, s_fall;

  assign sel    = ~cs_ni;
  assign h_fall = hold_prev_ni & ~hold_ni;
  assign h_rise = ~hold_prev_ni & hold_ni;
  assign s_fall = sck_prev_i & ~sck_i;

  always_comb begin
    st_d = st_q;
    if (!sel) begin
      st_d = HS_RUN;
    end else begin
      unique case (st_q)
        HS_RUN:    if (h_fall) st_d = sck_i ? HS_ARMED : HS_PAUSED;
        HS_ARMED: begin
          if (hold_ni)     st_d = HS_RUN;
          else if (s_fall) st_d = HS_PAUSED;
        end
        HS_PAUSED: if (h_rise && !sck_i) st_d = HS_RUN;
        default:   st_d = HS_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= HS_RUN;
      drive_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      drive_q <= sel && (st_d != HS_PAUSED);
    end
  end

  // the edge that starts a pause is withheld too
  assign block_o = (st_q == HS_PAUSED) || (st_d == HS_PAUSED);
  assign state_o = st_q;
  assign drive_o = drive_q;
endmodule

// File: rtl/so_gate.sv
module so_gate (
  input  logic drive_i,
  input  logic cs_ni,
  input  logic eng_so_i,
  input  logic eng_so_oe_i,
  output logic so_o,
  output logic so_oe_o
);
  logic oe;
  assign oe      = drive_i & ~cs_ni & eng_so_oe_i;
  assign so_oe_o = oe;
  assign so_o    = oe & eng_so_i;
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int unsigned IN_STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic hold_ni,
  input  logic si_i,
  input  logic eng_so_i,
  input  logic eng_so_oe_i,
  output logic eng_sck_rise_o,
  output logic eng_sck_fall_o,
  output logic eng_si_o,
  output logic paused_o,
  output logic so_o,
  output logic so_oe_o
);
  logic [PIN_W-1:0] pin_raw, pin_cur, pin_prev;
  logic        sck_cur, sck_prev, cs_n_cur, hold_n_cur, hold_n_prev, si_cur;
  logic        blocked, drive_en, si_hold_q;
  hold_state_e pause_st;

  always_comb begin
    pin_raw           = '0;
    pin_raw[PIN_SCK]  = sck_i;
    pin_raw[PIN_CS]   = cs_ni;
    pin_raw[PIN_HOLD] = hold_ni;
    pin_raw[PIN_SI]   = si_i;
  end

  spi_pin_stage #(
    .WIDTH  (PIN_W),
    .STAGES (IN_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_pins (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .cur_o (pin_cur),
    .prev_o(pin_prev)
  );

  assign sck_cur     = pin_cur[PIN_SCK];
  assign sck_prev    = pin_prev[PIN_SCK];
  assign cs_n_cur    = pin_cur[PIN_CS];
  assign hold_n_cur  = pin_cur[PIN_HOLD];
  assign hold_n_prev = pin_prev[PIN_HOLD];
  assign si_cur      = pin_cur[PIN_SI];

  hold_pause_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sck_i       (sck_cur),
    .sck_prev_i  (sck_prev),
    .hold_ni     (hold_n_cur),
    .hold_prev_ni(hold_n_prev),
    .cs_ni       (cs_n_cur),
    .state_o     (pause_st),
    .block_o     (blocked),
    .drive_o     (drive_en)
  );

  assign eng_sck_rise_o = ~cs_n_cur & ~blocked & sck_cur & ~sck_prev;
  assign eng_sck_fall_o = ~cs_n_cur & ~blocked & ~sck_cur & sck_prev;

  assign eng_si_o = blocked ? si_hold_q : si_cur;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) si_hold_q <= 1'b0;
    else         si_hold_q <= eng_si_o;
  end

  assign paused_o = (pause_st == HS_PAUSED);

  so_gate u_so (
    .drive_i    (drive_en),
    .cs_ni      (cs_n_cur),
    .eng_so_i   (eng_so_i),
    .eng_so_oe_i(eng_so_oe_i),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o)
  );
endmodule

// File: rtl/spi_hold_ctrl_sva.sv
module spi_hold_ctrl_sva
  import spi_hold_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_n_cur,
  input logic        sck_cur,
  input logic        hold_n_cur,
  input logic        hold_n_prev,
  input hold_state_e pause_st,
  input logic        eng_sck_rise_o,
  input logic        eng_sck_fall_o,
  input logic        eng_si_o,
  input logic        paused_o,
  input logic        so_oe_o
);
  a_r2_no_edge_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_cur |-> (!eng_sck_rise_o && !eng_sck_fall_o));

  a_r2_one_edge_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eng_sck_rise_o && eng_sck_fall_o));

  a_r3_enter_sck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_cur && pause_st == HS_RUN && hold_n_prev && !hold_n_cur && !sck_cur) |=> paused_o);

  a_r4_armed_waits_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_cur && pause_st == HS_ARMED && sck_cur && !hold_n_cur) |=> !paused_o);

  a_r6_no_resume_sck_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused_o && !cs_n_cur && sck_cur) |=> paused_o);

  a_r7_paused_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> (!eng_sck_rise_o && !eng_sck_fall_o && !so_oe_o));

  a_r7_si_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o |-> $stable(eng_si_o));

  a_r8_cs_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_cur |=> !paused_o);
endmodule

bind spi_hold_ctrl spi_hold_ctrl_sva u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_n_cur      (cs_n_cur),
  .sck_cur       (sck_cur),
  .hold_n_cur    (hold_n_cur),
  .hold_n_prev   (hold_n_prev),
  .pause_st      (pause_st),
  .eng_sck_rise_o(eng_sck_rise_o),
  .eng_sck_fall_o(eng_sck_fall_o),
  .eng_si_o      (eng_si_o),
  .paused_o      (paused_o),
  .so_oe_o       (so_oe_o)
);

// File: tb/spi_hold_ctrl_tb.sv
`timescale 1ns/1ps
module spi_hold_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic eso = 1'b1, eso_oe = 1'b1;
  logic rise, fall, esi, paused, so, so_oe;
  int   nchk = 0, nerr = 0, rise_cnt = 0, fall_cnt = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  spi_hold_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .hold_ni(hold_n),
    .si_i(si), .eng_so_i(eso), .eng_so_oe_i(eso_oe),
    .eng_sck_rise_o(rise), .eng_sck_fall_o(fall), .eng_si_o(esi),
    .paused_o(paused), .so_o(so), .so_oe_o(so_oe)
  );

  always @(negedge clk) begin
    if (rise) rise_cnt++;
    if (fall) fall_cnt++;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sck();
    sck = 1'b1; tick(2);
    sck = 1'b0; tick(2);
  endtask

  task automatic t_reset();
    chk("R1 paused", paused, 0);
    chk("R1 so_oe", so_oe, 0);
    chk("R1 so", so, 0);
    chk("R1 rise", rise, 0);
    chk("R1 fall", fall, 0);
  endtask

  task automatic t_pass();
    int r0, f0;
    cs_n = 1'b0; tick(3);
    chk("R9 so_oe follows engine", so_oe, 1);
    chk("R9 so data", so, 1);
    eso = 1'b0; tick(1);
    chk("R9 so data low", so, 0);
    eso = 1'b1;
    r0 = rise_cnt; f0 = fall_cnt;
    for (int i = 0; i < 4; i++) pulse_sck();
    chk("R2 rise count", rise_cnt - r0, 4);
    chk("R2 fall count", fall_cnt - f0, 4);
    eso_oe = 1'b0; tick(1);
    chk("R9 engine oe off", so_oe, 0);
    chk("R9 so zero when off", so, 0);
    eso_oe = 1'b1; tick(1);
  endtask

  task automatic t_deselect();
    int r0, f0;
    cs_n = 1'b1; tick(2);
    r0 = rise_cnt; f0 = fall_cnt;
    for (int i = 0; i < 3; i++) pulse_sck();
    chk("R2 no rise deselected", rise_cnt - r0, 0);
    chk("R2 no fall deselected", fall_cnt - f0, 0);
    cs_n = 1'b0; tick(3);
  endtask

  task automatic t_enter_low();
    int r0, f0;
    logic si_frozen;
    si = 1'b1; tick(2);
    hold_n = 1'b0; tick(1);
    chk("R3 not yet paused", paused, 0);
    tick(1);
    chk("R3 paused", paused, 1);
    chk("R7 so off", so_oe, 0);
    si_frozen = esi;
    r0 = rise_cnt; f0 = fall_cnt;
    si = 1'b0;
    for (int i = 0; i < 3; i++) pulse_sck();
    chk("R7 no rise", rise_cnt - r0, 0);
    chk("R7 no fall", fall_cnt - f0, 0);
    chk("R7 si held", esi, si_frozen);
    hold_n = 1'b1; tick(2);
    chk("R6 resumed", paused, 0);
    chk("R6 so back", so_oe, 1);
    chk("R6 si live", esi, 0);
    r0 = rise_cnt;
    pulse_sck();
    chk("R6 edges resume", rise_cnt - r0, 1);
  endtask

  task automatic t_enter_high();
    int f0;
    sck = 1'b1; tick(2);
    hold_n = 1'b0; tick(3);
    chk("R4 waits while sck high", paused, 0);
    f0 = fall_cnt;
    sck = 1'b0; tick(1);
    chk("R4 pause not yet visible", paused, 0);
    tick(1);
    chk("R4 paused at fall", paused, 1);
    chk("R4 fall withheld", fall_cnt - f0, 0);
    hold_n = 1'b1; tick(2);
    chk("R6 resume after deferred", paused, 0);
  endtask

  task automatic t_cancel();
    int f0;
    sck = 1'b1; tick(2);
    hold_n = 1'b0; tick(2);
    hold_n = 1'b1; tick(2);
    f0 = fall_cnt;
    sck = 1'b0; tick(3);
    chk("R5 no pause", paused, 0);
    chk("R5 fall delivered", fall_cnt - f0, 1);
  endtask

  task automatic t_resume_high();
    hold_n = 1'b0; tick(2);
    sck = 1'b1; tick(2);
    hold_n = 1'b1; tick(2);
    sck = 1'b0; tick(3);
    chk("R6 stays paused", paused, 1);
    chk("R6 so stays off", so_oe, 0);
    hold_n = 1'b0; tick(2);
    hold_n = 1'b1; tick(2);
    chk("R6 resumed low", paused, 0);
  endtask

  task automatic t_cs_clear();
    int r0;
    hold_n = 1'b0; tick(2);
    chk("R8 paused before", paused, 1);
    cs_n = 1'b1; tick(2);
    chk("R8 cleared", paused, 0);
    hold_n = 1'b1; tick(1);
    cs_n = 1'b0; tick(3);
    chk("R8 unpaused on select", paused, 0);
    r0 = rise_cnt;
    pulse_sck();
    chk("R8 edges pass", rise_cnt - r0, 1);
  endtask

  task automatic t_hold_deselected();
    int r0;
    cs_n = 1'b1; tick(2);
    hold_n = 1'b0; tick(2);
    cs_n = 1'b0; tick(3);
    chk("R10 not paused", paused, 0);
    r0 = rise_cnt;
    pulse_sck();
    chk("R10 edges pass", rise_cnt - r0, 1);
    hold_n = 1'b1; tick(2);
    chk("R10 still not paused", paused, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1; tick(2);
    t_reset();
    t_pass();
    t_deselect();
    t_enter_low();
    t_enter_high();
    t_cancel();
    t_resume_high();
    t_cs_clear();
    t_hold_deselected();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule